// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block watches the access traffic of the two ports of a shared memory and gives each port an interrupt flag for passing messages. Two addresses at the very top of the address space are set aside as mailboxes. The top address belongs to the right port and the address just below it belongs to the left port. When one port writes into the mailbox of the other port, the owner's flag goes active. When the owner later reads its own mailbox, the flag returns to idle.

The controller never sees the data. The meaning of each message is left to the software on both sides, and the memory array sits outside this block. Each port presents an address, an enable and a write strobe in every clock cycle. The flags are registered, and a flag changes on the clock edge that samples the access.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, both `left_irq_n` and `right_irq_n` are 1 (inactive).
- R2: An enabled write by the left port (`left_en`=1, `left_we`=1) to address all-ones (2^ADDR_W-1) drives `right_irq_n` to 0 from the next clock edge.
- R3: An enabled write by the right port to address all-ones minus one (2^ADDR_W-2) drives `left_irq_n` to 0 from the next clock edge.
- R4: An enabled read (`*_en`=1, `*_we`=0) by a port of its own mailbox (right: all-ones, left: all-ones minus one) returns that port's flag to 1 from the next clock edge.
- R5: A port that writes into its own mailbox leaves its own flag unchanged.
- R6: If the setting write and the clearing read of one flag fall in the same cycle, the flag is 0 after that edge.
- R7: Accesses with enable 0, and accesses to any address other than the two mailboxes, leave both flags unchanged.
- R8: A read of a mailbox by the port that does not own it does not clear the owner's flag.
- R9: With no setting or clearing access, a flag keeps its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| left_addr | input | ADDR_W | Left port address |
| left_en | input | 1 | Left port access enable |
| left_we | input | 1 | Left port write (1) or read (0) |
| right_addr | input | ADDR_W | Right port address |
| right_en | input | 1 | Right port access enable |
| right_we | input | 1 | Right port write (1) or read (0) |
| left_irq_n | output | 1 | Left port interrupt flag, active low |
| right_irq_n | output | 1 | Right port interrupt flag, active low |

## Verification
The hardest case to reach is the collision in which a flag is set and cleared in the same cycle. It needs the writer and the owner to reach the same mailbox in one cycle, with opposite directions. The bench drives both ports in a single call for that cycle. It runs the collision once while the flag is already active and once while it is idle, so that the priority is the only thing that can explain the outcome. The bench also has a non-owner read a mailbox that already holds an active flag, which shows that only the owner's read clears it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned PORTS = 2;
   localparam int unsigned LEFT  = 0;
   localparam int unsigned RIGHT = 1;

   function automatic logic [63:0] box_of(input int unsigned side, input int unsigned aw);
      logic [63:0] top;
      top = (64'd1 << aw) - 64'd1;
      return (side == RIGHT) ? top : top - 64'd1;
   endfunction
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
   parameter int unsigned ADDR_W   = 15,
   parameter int unsigned OWN_BOX  = 0,
   parameter int unsigned PEER_BOX = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   input  logic              we,
   output logic              own_rd,
   output logic              peer_wr
);
   localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
   localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

   always_comb begin
      own_rd  = en && !we && (addr == OWN_A);
      peer_wr = en &&  we && (addr == PEER_A);
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (set)      nxt = 1'b0;
            else if (clr) nxt = 1'b1;
            else          nxt = irq_n;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr)      nxt = 1'b1;
            else if (set) nxt = 1'b0;
            else          nxt = irq_n;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= nxt;
   end

   // R2, R3, R6: a set always wins at the next edge (default priority)
   p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (set && SET_WINS) |=> !irq_n);
   // R4: a lone clear deasserts
   p_clr_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> irq_n);
   // R9: nothing happens, nothing changes
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
   parameter int unsigned ADDR_W   = 15,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] left_addr,
   input  logic              left_en,
   input  logic              left_we,
   input  logic [ADDR_W-1:0] right_addr,
   input  logic              right_en,
   input  logic              right_we,
   output logic              left_irq_n,
   output logic              right_irq_n
);
   import mbx_pkg::*;

   localparam logic [ADDR_W-1:0] LEFT_BOX  = ADDR_W'(box_of(LEFT, ADDR_W));
   localparam logic [ADDR_W-1:0] RIGHT_BOX = ADDR_W'(box_of(RIGHT, ADDR_W));

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
         $error("mbx_irq_ctrl: ADDR_W must lie in 2..32");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_v [PORTS];
   logic [PORTS-1:0]  en_v, we_v, own_rd, peer_wr, irq_v;

   assign addr_v[LEFT]  = left_addr;
   assign addr_v[RIGHT] = right_addr;
   assign en_v = {right_en, left_en};
   assign we_v = {right_we, left_we};

   generate
      for (genvar i = 0; i < PORTS; i++) begin : g_port
         mbx_port_dec #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (int'(box_of(i, ADDR_W))),
            .PEER_BOX(int'(box_of(PORTS - 1 - i, ADDR_W)))
         ) u_dec (
            .addr   (addr_v[i]),
            .en     (en_v[i]),
            .we     (we_v[i]),
            .own_rd (own_rd[i]),
            .peer_wr(peer_wr[i])
         );

         mbx_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (peer_wr[PORTS - 1 - i]),
            .clr  (own_rd[i]),
            .irq_n(irq_v[i])
         );
      end
   endgenerate

   assign left_irq_n  = irq_v[LEFT];
   assign right_irq_n = irq_v[RIGHT];

   // R2: left write into right mailbox raises right flag
   p_left_sets_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (left_en && left_we && left_addr == RIGHT_BOX && SET_WINS) |=> !right_irq_n);
   // R3: right write into left mailbox raises left flag
   p_right_sets_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (right_en && right_we && right_addr == LEFT_BOX && SET_WINS) |=> !left_irq_n);
   // R5: self write leaves own flag alone
   p_self_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (left_en && left_we && left_addr == LEFT_BOX &&
       !(right_en && right_we && right_addr == LEFT_BOX))
      |=> left_irq_n == $past(left_irq_n));
   // R8: non-owner read does not clear
   p_foreign_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!right_irq_n && left_en && !left_we && left_addr == RIGHT_BOX &&
       !(right_en && !right_we && right_addr == RIGHT_BOX)) |=> !right_irq_n);
endmodule

// File: tb/mbx_irq_ctrl_test.sv
module mbx_irq_ctrl_test;
   localparam int unsigned AW = 15;
   localparam logic [AW-1:0] RBOX = {AW{1'b1}};
   localparam logic [AW-1:0] LBOX = {{(AW-1){1'b1}}, 1'b0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_en = 1'b0, l_we = 1'b0, r_en = 1'b0, r_we = 1'b0;
   logic l_irq_n, r_irq_n;
   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   mbx_irq_ctrl #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n),
      .left_addr(l_addr), .left_en(l_en), .left_we(l_we),
      .right_addr(r_addr), .right_en(r_en), .right_we(r_we),
      .left_irq_n(l_irq_n), .right_irq_n(r_irq_n)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // one cycle of accesses on both ports, then idle; returns at the next falling edge
   task automatic cyc(input logic le, input logic lw, input logic [AW-1:0] la,
                      input logic re, input logic rw, input logic [AW-1:0] ra);
      @(negedge clk);
      l_en = le; l_we = lw; l_addr = la;
      r_en = re; r_we = rw; r_addr = ra;
      @(negedge clk);
      l_en = 1'b0; r_en = 1'b0;
   endtask

   task automatic t_reset;
      chk(l_irq_n, 1'b1, "R1 left during reset");
      chk(r_irq_n, 1'b1, "R1 right during reset");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(l_irq_n, 1'b1, "R1 left after reset");
      chk(r_irq_n, 1'b1, "R1 right after reset");
   endtask

   task automatic t_right_box;
      cyc(1, 1, RBOX, 0, 0, '0);
      chk(r_irq_n, 1'b0, "R2 left write sets right");
      chk(l_irq_n, 1'b1, "R2 left flag untouched");
      repeat (5) @(negedge clk);
      chk(r_irq_n, 1'b0, "R9 right holds");
      cyc(1, 0, RBOX, 0, 0, '0);
      chk(r_irq_n, 1'b0, "R8 left read of right box");
      cyc(0, 0, '0, 1, 0, RBOX);
      chk(r_irq_n, 1'b1, "R4 right read clears");
   endtask

   task automatic t_left_box;
      cyc(0, 0, '0, 1, 1, LBOX);
      chk(l_irq_n, 1'b0, "R3 right write sets left");
      chk(r_irq_n, 1'b1, "R3 right flag untouched");
      cyc(0, 0, '0, 1, 0, LBOX);
      chk(l_irq_n, 1'b0, "R8 right read of left box");
      cyc(1, 0, LBOX, 0, 0, '0);
      chk(l_irq_n, 1'b1, "R4 left read clears");
   endtask

   task automatic t_self;
      cyc(1, 1, LBOX, 1, 1, RBOX);
      chk(l_irq_n, 1'b1, "R5 left self write");
      chk(r_irq_n, 1'b1, "R5 right self write");
      cyc(0, 0, '0, 1, 1, LBOX);
      cyc(1, 1, LBOX, 0, 0, '0);
      chk(l_irq_n, 1'b0, "R5 self write keeps active flag");
      cyc(1, 0, LBOX, 0, 0, '0);
      chk(l_irq_n, 1'b1, "R4 left clear after self write");
   endtask

   task automatic t_ignored;
      cyc(0, 1, RBOX, 0, 1, LBOX);
      chk(r_irq_n, 1'b1, "R7 disabled left write");
      chk(l_irq_n, 1'b1, "R7 disabled right write");
      cyc(1, 1, RBOX - 2, 1, 1, '0);
      chk(r_irq_n, 1'b1, "R7 other address left");
      chk(l_irq_n, 1'b1, "R7 other address right");
      cyc(1, 1, RBOX, 1, 1, LBOX);
      cyc(1, 0, RBOX - 2, 0, 0, RBOX);
      chk(l_irq_n, 1'b0, "R7 left read elsewhere keeps flag");
      chk(r_irq_n, 1'b0, "R7 disabled right read keeps flag");
      cyc(1, 0, LBOX, 1, 0, RBOX);
      chk(l_irq_n, 1'b1, "R4 both clear left");
      chk(r_irq_n, 1'b1, "R4 both clear right");
   endtask

   task automatic t_collide;
      cyc(1, 1, RBOX, 1, 0, RBOX);
      chk(r_irq_n, 1'b0, "R6 collision from idle");
      cyc(1, 1, RBOX, 1, 0, RBOX);
      chk(r_irq_n, 1'b0, "R6 collision while active");
      cyc(0, 0, '0, 1, 0, RBOX);
      chk(r_irq_n, 1'b1, "R4 clear after collision");
      cyc(1, 0, LBOX, 1, 1, LBOX);
      chk(l_irq_n, 1'b0, "R6 left collision");
      cyc(1, 0, LBOX, 0, 0, '0);
      chk(l_irq_n, 1'b1, "R4 left clear after collision");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_right_box();
      t_left_box();
      t_self();
      t_ignored();
      t_collide();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule